// File: doc/BRIEF.md
# Four-Channel DMA Register Bank

This block is the register-level heart of a four-channel DMA controller. Software programs it through a byte-wide port. Each channel holds a 16-bit starting address and a 16-bit count. Each value is kept as a base copy and a working copy. Each channel also has a mode byte. The block-level state is a mask bit per channel and a terminal-count flag per channel. Because the port is only eight bits wide, every 16-bit value is moved as two byte accesses. A single shared byte pointer decides whether an access hits the low or the high half. Software resets that pointer with a dedicated clear port.

Peripherals raise one request line per channel. On every clock, the lowest-numbered requesting channel that is not masked is acknowledged. For that transfer the block presents the channel's working address and direction. Unless the channel is in cascade mode, its address is stepped up by one and its count down by one. A count that passes from zero to all ones is a terminal count. Terminal count sets the channel's status flag. If auto-initialize is on, it also reloads the working registers from the base copies.

Top module: `dma_regbank`

## Requirements
- R1: After reset all four mask bits are set (mask port reads 0x0F), the byte pointer selects the low byte, and the status port reads 0x00.
- R2: Register select 2*ch addresses channel ch's address port and 2*ch+1 its count port. A write loads both the base and the working copy. Successive accesses (read or write) alternate low byte then high byte through one shared pointer. Reads return the working value.
- R3: Any write to select 11 returns the byte pointer to the low byte, whatever data it carries.
- R4: A write to select 9 sets the mask bit of channel data[1:0] when data[2] is 1 and clears it when data[2] is 0. The other mask bits are unchanged.
- R5: A write to select 12 loads all four mask bits from data[3:0]. Select 12 reads back the mask in bits 3:0, with bits 7:4 zero.
- R6: A masked channel is never acknowledged, and its working address and count do not change while it requests.
- R7: ack is one-hot or zero, and goes to the lowest-numbered unmasked requesting channel. xfer_addr shows that channel's working address before the step. A non-cascade transfer adds one to the address and subtracts one from the count.
- R8: A transfer taken while the count is zero raises xfer_tc and sets the channel's flag in status bits 3:0. Without auto-initialize the count becomes 0xFFFF and the address keeps counting up.
- R9: With auto-initialize (mode bit 4) on, a terminal-count transfer reloads the working address and count from their base copies.
- R10: Reading select 8 returns the terminal-count flags in bits 3:0 and then clears them. A flag raised in the same cycle as the read survives.
- R11: A write to select 10 sets the mode of channel data[1:0]. A channel whose mode bits 7:6 are 11 (cascade) is acknowledged but its address and count stay unchanged.
- R12: xfer_to_mem equals mode bit 2 of the acknowledged channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe; side effects take place at the clock edge |
| reg_sel | input | 4 | Register select |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the selected register |
| req | input | 4 | Per-channel transfer requests |
| ack | output | 4 | Acknowledge of the channel served this cycle |
| xfer_addr | output | 16 | Working address of the acknowledged channel |
| xfer_to_mem | output | 1 | Direction of the acknowledged transfer |
| xfer_tc | output | 1 | The acknowledged transfer ends its count |

## Verification
The bench builds the block with its default parameters: four channels with 16-bit registers behind an 8-bit port. These defaults let the shared byte pointer, the 0-to-0xFFFF count wrap and the auto-initialize reload all occur within a few programmed cycles. Short counts of zero, one and two put terminal count within reach in one to three transfers. The bench also overlaps a status read with a terminal count, requests all channels while all are masked, and raises two requests at once to exercise priority.

// File: rtl/dma_regbank_pkg.sv
package dma_regbank_pkg;

    localparam int NUM_CH = 4;
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int SEL_W  = 4;
    localparam int CHAN_PORTS = 2 * NUM_CH;

    localparam logic [SEL_W-1:0] SEL_STATUS = SEL_W'(8);
    localparam logic [SEL_W-1:0] SEL_SMASK  = SEL_W'(9);
    localparam logic [SEL_W-1:0] SEL_MODE   = SEL_W'(10);
    localparam logic [SEL_W-1:0] SEL_CLRPTR = SEL_W'(11);
    localparam logic [SEL_W-1:0] SEL_AMASK  = SEL_W'(12);

    typedef enum logic [1:0] {
        XF_DEMAND  = 2'b00,
        XF_SINGLE  = 2'b01,
        XF_BLOCK   = 2'b10,
        XF_CASCADE = 2'b11
    } xfer_kind_e;

    typedef struct packed {
        xfer_kind_e kind;
        logic       autoinit;
        logic       to_mem;
    } chan_mode_t;

    function automatic chan_mode_t unpack_mode(input logic [BYTE_W-1:0] b);
        chan_mode_t m;
        m.kind     = xfer_kind_e'(b[7:6]);
        m.autoinit = b[4];
        m.to_mem   = b[2];
        return m;
    endfunction

    function automatic logic is_chan_port(input logic [SEL_W-1:0] s);
        return s < SEL_W'(CHAN_PORTS);
    endfunction

endpackage

// File: rtl/dma_port_decode.sv
module dma_port_decode
    import dma_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [SEL_W-1:0]  sel,
    output logic [NUM_CH-1:0] addr_we,
    output logic [NUM_CH-1:0] cnt_we,
    output logic              hi_byte,
    output logic              mode_we,
    output logic              smask_we,
    output logic              amask_we,
    output logic              status_rd,
    output logic [CH_W-1:0]   port_ch,
    output logic              port_cnt
);
    logic ptr_q;
    logic chan_port;
    logic access;
    logic clr_ptr;

    assign chan_port = is_chan_port(sel);
    assign access    = chan_port && (wr_en || rd_en);
    assign clr_ptr   = wr_en && (sel == SEL_CLRPTR);
    assign port_ch   = sel[CH_W:1];
    assign port_cnt  = sel[0];
    assign hi_byte   = ptr_q;

    assign mode_we   = wr_en && (sel == SEL_MODE);
    assign smask_we  = wr_en && (sel == SEL_SMASK);
    assign amask_we  = wr_en && (sel == SEL_AMASK);
    assign status_rd = rd_en && (sel == SEL_STATUS);

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            addr_we[i] = wr_en && chan_port && (port_ch == CH_W'(i)) && !port_cnt;
            cnt_we[i]  = wr_en && chan_port && (port_ch == CH_W'(i)) &&  port_cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          ptr_q <= 1'b0;
        else if (clr_ptr) ptr_q <= 1'b0;
        else if (access)  ptr_q <= ~ptr_q;
    end

    // R2: every channel-port access flips the shared pointer
    p_ptr_flip_r2: assert property (@(posedge clk) disable iff (rst)
        access |=> (ptr_q != $past(ptr_q)));

    // R3: clear port always returns the pointer to the low byte
    p_ptr_clear_r3: assert property (@(posedge clk) disable iff (rst)
        clr_ptr |=> !ptr_q);

endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
    parameter int N = 4
) (
    input  logic [N-1:0] elig,
    output logic [N-1:0] grant
);
    always_comb begin
        logic taken;
        taken = 1'b0;
        for (int i = 0; i < N; i++) begin
            grant[i] = elig[i] && !taken;
            taken    = taken || elig[i];
        end
    end
endmodule

// File: rtl/dma_channel.sv
module dma_channel
    import dma_regbank_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_we,
    input  logic              cnt_we,
    input  logic              hi_byte,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              mode_we,
    input  logic              step,
    output logic [W-1:0]      cur_addr,
    output logic [W-1:0]      cur_cnt,
    output logic              to_mem,
    output logic              tc_hit
);
    localparam int HALF = W / 2;

    logic [W-1:0] base_a, base_c, cur_a, cur_c;
    chan_mode_t   mode_q;
    logic         advance;
    logic         no_cpu;

    assign advance  = step && (mode_q.kind != XF_CASCADE);
    assign tc_hit   = advance && (cur_c == '0);
    assign cur_addr = cur_a;
    assign cur_cnt  = cur_c;
    assign to_mem   = mode_q.to_mem;
    assign no_cpu   = !addr_we && !cnt_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_a <= '0;
            base_c <= '0;
            cur_a  <= '0;
            cur_c  <= '0;
            mode_q <= '0;
        end else begin
            if (advance) begin
                if (tc_hit && mode_q.autoinit) begin
                    cur_a <= base_a;
                    cur_c <= base_c;
                end else begin
                    cur_a <= cur_a + W'(1);
                    cur_c <= cur_c - W'(1);
                end
            end
            if (addr_we) begin
                if (hi_byte) begin
                    base_a[W-1:HALF] <= wdata;
                    cur_a[W-1:HALF]  <= wdata;
                end else begin
                    base_a[HALF-1:0] <= wdata;
                    cur_a[HALF-1:0]  <= wdata;
                end
            end
            if (cnt_we) begin
                if (hi_byte) begin
                    base_c[W-1:HALF] <= wdata;
                    cur_c[W-1:HALF]  <= wdata;
                end else begin
                    base_c[HALF-1:0] <= wdata;
                    cur_c[HALF-1:0]  <= wdata;
                end
            end
            if (mode_we) mode_q <= unpack_mode(wdata);
        end
    end

    // R7: ordinary step moves address up and count down by one
    p_step_r7: assert property (@(posedge clk) disable iff (rst)
        (advance && cur_c != '0 && no_cpu) |=>
            (cur_c == $past(cur_c) - W'(1)) && (cur_a == $past(cur_a) + W'(1)));

    // R8: without auto-initialize the count wraps to all ones
    p_tc_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        (tc_hit && !mode_q.autoinit && no_cpu) |=> (cur_c == '1));

    // R9: with auto-initialize the working registers take the base copies
    p_reload_r9: assert property (@(posedge clk) disable iff (rst)
        (tc_hit && mode_q.autoinit && no_cpu) |=>
            (cur_c == $past(base_c)) && (cur_a == $past(base_a)));

    // R11: cascade grants leave the registers alone
    p_cascade_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (step && mode_q.kind == XF_CASCADE && no_cpu) |=>
            $stable(cur_c) && $stable(cur_a));

endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
    import dma_regbank_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [3:0]  reg_sel,
    input  logic [7:0]  wr_data,
    output logic [7:0]  rd_data,
    input  logic [3:0]  req,
    output logic [3:0]  ack,
    output logic [15:0] xfer_addr,
    output logic        xfer_to_mem,
    output logic        xfer_tc
);
    logic [NUM_CH-1:0] addr_we, cnt_we, grant, elig, tc_hits, ch_to_mem;
    logic              hi_byte, mode_we, smask_we, amask_we, status_rd, port_cnt;
    logic [CH_W-1:0]   port_ch;
    logic [NUM_CH-1:0] mask_q, tc_q;
    logic [WORD_W-1:0] ch_addr [NUM_CH];
    logic [WORD_W-1:0] ch_cnt  [NUM_CH];

    dma_port_decode u_dec (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .sel(reg_sel),
        .addr_we(addr_we), .cnt_we(cnt_we), .hi_byte(hi_byte),
        .mode_we(mode_we), .smask_we(smask_we), .amask_we(amask_we),
        .status_rd(status_rd), .port_ch(port_ch), .port_cnt(port_cnt)
    );

    assign elig = req & ~mask_q;

    dma_prio_arb #(.N(NUM_CH)) u_arb (.elig(elig), .grant(grant));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dma_channel #(.W(WORD_W)) u_ch (
            .clk(clk), .rst(rst),
            .addr_we(addr_we[g]), .cnt_we(cnt_we[g]), .hi_byte(hi_byte),
            .wdata(wr_data),
            .mode_we(mode_we && (wr_data[CH_W-1:0] == CH_W'(g))),
            .step(grant[g]),
            .cur_addr(ch_addr[g]), .cur_cnt(ch_cnt[g]),
            .to_mem(ch_to_mem[g]), .tc_hit(tc_hits[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            tc_q   <= '0;
        end else begin
            if (amask_we)      mask_q <= wr_data[NUM_CH-1:0];
            else if (smask_we) mask_q[wr_data[CH_W-1:0]] <= wr_data[2];
            tc_q <= (status_rd ? '0 : tc_q) | tc_hits;
        end
    end

    always_comb begin
        logic [WORD_W-1:0] word;
        word    = port_cnt ? ch_cnt[port_ch] : ch_addr[port_ch];
        rd_data = '0;
        if (is_chan_port(reg_sel))      rd_data = hi_byte ? word[WORD_W-1:BYTE_W] : word[BYTE_W-1:0];
        else if (reg_sel == SEL_STATUS) rd_data = BYTE_W'(tc_q);
        else if (reg_sel == SEL_AMASK)  rd_data = BYTE_W'(mask_q);
    end

    always_comb begin
        xfer_addr   = '0;
        xfer_to_mem = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (grant[i]) begin
                xfer_addr   = xfer_addr | ch_addr[i];
                xfer_to_mem = xfer_to_mem | ch_to_mem[i];
            end
        end
    end

    assign ack     = grant;
    assign xfer_tc = |tc_hits;

    // R1: mask comes out of reset fully set
    p_mask_reset_r1: assert property (@(posedge clk) $fell(rst) |-> (mask_q == '1));

    // R7: at most one channel served per cycle
    p_ack_onehot_r7: assert property (@(posedge clk) disable iff (rst) $onehot0(ack));

    // R6: masked channels are never acknowledged
    p_masked_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (ack & mask_q) == '0);

    // R4: single-mask write updates only the addressed bit
    p_smask_r4: assert property (@(posedge clk) disable iff (rst)
        (smask_we && !amask_we) |=> (mask_q[$past(wr_data[1:0])] == $past(wr_data[2])));

    // R8: terminal count leaves the served channel's flag set
    p_tc_flag_r8: assert property (@(posedge clk) disable iff (rst)
        xfer_tc |=> ((tc_q & $past(ack)) != '0));

    // R10: a status read with no new terminal count empties the flags
    p_status_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (status_rd && !xfer_tc) |=> (tc_q == '0));

endmodule

// File: tb/dma_regbank_tb_top.sv
`timescale 1ns/1ps
module dma_regbank_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0]  reg_sel = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [3:0]  req = '0;
    logic [3:0]  ack;
    logic [15:0] xfer_addr;
    logic        xfer_to_mem, xfer_tc;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dma_regbank dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
        .wr_data(wr_data), .rd_data(rd_data), .req(req), .ack(ack),
        .xfer_addr(xfer_addr), .xfer_to_mem(xfer_to_mem), .xfer_tc(xfer_tc)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [15:0] ma_base [4], ma_cur [4], mc_base [4], mc_cur [4];
    logic [7:0]  m_mode [4];
    logic [3:0]  m_mask, m_tc;
    bit          m_ptr;

    function automatic logic [7:0] model_rd(input logic [3:0] s);
        logic [15:0] v;
        if (s < 8) begin
            v = s[0] ? mc_cur[s/2] : ma_cur[s/2];
            return m_ptr ? v[15:8] : v[7:0];
        end
        if (s == 8)  return {4'b0, m_tc};
        if (s == 12) return {4'b0, m_mask};
        return 8'h00;
    endfunction

    always @(negedge clk) begin
        int idx;
        logic [3:0] newtc;
        if (rst) begin
            for (int i = 0; i < 4; i++) begin
                ma_base[i] = 0; ma_cur[i] = 0; mc_base[i] = 0; mc_cur[i] = 0; m_mode[i] = 0;
            end
            m_mask = 4'hF; m_tc = 0; m_ptr = 0;
        end else begin
            idx = -1;
            for (int i = 0; i < 4; i++)
                if (idx < 0 && req[i] && !m_mask[i]) idx = i;
            chk("R7 model ack", ack, (idx < 0) ? 4'h0 : 4'(1 << idx));
            newtc = 0;
            if (idx >= 0) begin
                chk("R7 model xfer_addr", xfer_addr, ma_cur[idx]);
                chk("R12 model xfer_to_mem", xfer_to_mem, m_mode[idx][2]);
                chk("R8 model xfer_tc", xfer_tc, (m_mode[idx][7:6] != 2'b11) && (mc_cur[idx] == 0));
                if (m_mode[idx][7:6] != 2'b11) begin
                    if (mc_cur[idx] == 0) begin
                        newtc[idx] = 1'b1;
                        if (m_mode[idx][4]) begin
                            ma_cur[idx] = ma_base[idx]; mc_cur[idx] = mc_base[idx];
                        end else begin
                            ma_cur[idx] = ma_cur[idx] + 1; mc_cur[idx] = 16'hFFFF;
                        end
                    end else begin
                        ma_cur[idx] = ma_cur[idx] + 1; mc_cur[idx] = mc_cur[idx] - 1;
                    end
                end
            end else begin
                chk("R8 model idle xfer_tc", xfer_tc, 0);
            end
            if (rd_en) begin
                chk("R2 model rd_data", rd_data, model_rd(reg_sel));
                if (reg_sel == 8) m_tc = 0;
            end
            if (wr_en) begin
                if (reg_sel < 8) begin
                    int ch;
                    ch = reg_sel / 2;
                    if (reg_sel[0]) begin
                        if (m_ptr) begin mc_base[ch][15:8] = wr_data; mc_cur[ch][15:8] = wr_data; end
                        else       begin mc_base[ch][7:0]  = wr_data; mc_cur[ch][7:0]  = wr_data; end
                    end else begin
                        if (m_ptr) begin ma_base[ch][15:8] = wr_data; ma_cur[ch][15:8] = wr_data; end
                        else       begin ma_base[ch][7:0]  = wr_data; ma_cur[ch][7:0]  = wr_data; end
                    end
                end
                case (reg_sel)
                    4'd9:  m_mask[wr_data[1:0]] = wr_data[2];
                    4'd10: m_mode[wr_data[1:0]] = wr_data;
                    4'd11: m_ptr = 0;
                    4'd12: m_mask = wr_data[3:0];
                    default: ;
                endcase
            end
            if ((rd_en || wr_en) && reg_sel < 8) m_ptr = !m_ptr;
            m_tc = m_tc | newtc;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic drive(input logic we, input logic re, input logic [3:0] s,
                         input logic [7:0] d, input logic [3:0] r);
        @(posedge clk); #1;
        wr_en = we; rd_en = re; reg_sel = s; wr_data = d; req = r;
    endtask

    task automatic wr(input logic [3:0] s, input logic [7:0] d);
        drive(1'b1, 1'b0, s, d, 4'h0);
    endtask

    task automatic rd(input logic [3:0] s, input logic [3:0] r, output logic [7:0] d);
        drive(1'b0, 1'b1, s, 8'h00, r);
        @(negedge clk); d = rd_data;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] s, input logic [7:0] exp);
        logic [7:0] d;
        rd(s, 4'h0, d);
        chk(tag, d, exp);
    endtask

    task automatic run(input logic [3:0] r, input int n);
        drive(1'b0, 1'b0, 4'h0, 8'h00, r);
        repeat (n - 1) @(posedge clk);
    endtask

    task automatic sample(input logic [3:0] r, output logic [3:0] a,
                          output logic dir, output logic tc);
        drive(1'b0, 1'b0, 4'h0, 8'h00, r);
        @(negedge clk); a = ack; dir = xfer_to_mem; tc = xfer_tc;
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 4'h0, 8'h00, 4'h0);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #1000000;
        checks++; errors++;
        $display("FAIL watchdog (all) actual=hung expected=done");
        summary();
    end

    initial begin
        logic [3:0] a;
        logic       dir, tc;
        logic [7:0] d;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd_chk("R1 mask after reset", 4'd12, 8'h0F);
        rd_chk("R1 status after reset", 4'd8, 8'h00);

        // R1/R2 pointer starts low: program channel 0 without clearing first
        wr(4'd0, 8'h34); wr(4'd0, 8'h12);
        wr(4'd1, 8'h02); wr(4'd1, 8'h00);
        wr(4'd10, 8'h44);                      // ch0: single, to memory
        rd_chk("R2 addr lo", 4'd0, 8'h34);
        rd_chk("R2 addr hi", 4'd0, 8'h12);
        rd_chk("R2 count lo", 4'd1, 8'h02);
        rd_chk("R2 count hi", 4'd1, 8'h00);

        // R3 clear pointer after a stray byte
        wr(4'd2, 8'hAA); wr(4'd11, 8'h5A);
        wr(4'd2, 8'h10); wr(4'd2, 8'h20);
        rd_chk("R3 ch1 addr lo", 4'd2, 8'h10);
        rd_chk("R3 ch1 addr hi", 4'd2, 8'h20);

        // R6 masked channel ignores requests
        run(4'h1, 3);
        rd_chk("R6 ch0 count lo unchanged", 4'd1, 8'h02);
        rd_chk("R6 ch0 count hi unchanged", 4'd1, 8'h00);

        // R4 single mask writes
        wr(4'd9, 8'h00);
        rd_chk("R4 unmask ch0", 4'd12, 8'h0E);
        wr(4'd9, 8'h01);
        rd_chk("R4 unmask ch1", 4'd12, 8'h0C);
        wr(4'd9, 8'h05);
        rd_chk("R4 remask ch1", 4'd12, 8'h0E);

        // R7/R8 three transfers on ch0 with count 2
        run(4'h1, 3);
        rd_chk("R8 status flag ch0", 4'd8, 8'h01);
        rd_chk("R10 status cleared", 4'd8, 8'h00);
        rd_chk("R8 wrapped count lo", 4'd1, 8'hFF);
        rd_chk("R8 wrapped count hi", 4'd1, 8'hFF);
        rd_chk("R7 stepped addr lo", 4'd0, 8'h37);
        rd_chk("R7 stepped addr hi", 4'd0, 8'h12);

        // R9 auto-initialize on ch1 (count 1, read direction)
        wr(4'd10, 8'h51);
        wr(4'd3, 8'h01); wr(4'd3, 8'h00);
        wr(4'd12, 8'h00);
        rd_chk("R5 all unmasked", 4'd12, 8'h00);
        run(4'h2, 3);
        rd_chk("R9 ch1 addr lo", 4'd2, 8'h11);
        rd_chk("R9 ch1 addr hi", 4'd2, 8'h20);
        rd_chk("R9 ch1 count lo", 4'd3, 8'h00);
        rd_chk("R9 ch1 count hi", 4'd3, 8'h00);
        rd_chk("R9 ch1 flag", 4'd8, 8'h02);

        // R7 priority and R12 direction
        sample(4'h3, a, dir, tc);
        chk("R7 lowest channel wins", a, 4'h1);
        chk("R12 ch0 to memory", dir, 1'b1);
        sample(4'h2, a, dir, tc);
        chk("R7 ch1 alone", a, 4'h2);
        chk("R12 ch1 from memory", dir, 1'b0);
        chk("R8 ch1 tc pulse", tc, 1'b1);

        // R11 cascade channel
        wr(4'd10, 8'hC2);
        wr(4'd5, 8'h05); wr(4'd5, 8'h00);
        sample(4'h4, a, dir, tc);
        chk("R11 cascade acked", a, 4'h4);
        chk("R11 cascade no tc", tc, 1'b0);
        run(4'h4, 3);
        rd_chk("R11 cascade count lo", 4'd5, 8'h05);
        rd_chk("R11 cascade count hi", 4'd5, 8'h00);

        // R5 all masked
        wr(4'd12, 8'h0F);
        sample(4'hF, a, dir, tc);
        chk("R5 all masked no ack", a, 4'h0);
        rd_chk("R5 mask readback", 4'd12, 8'h0F);

        // R10 terminal count in the same cycle as a status read
        wr(4'd10, 8'h43);
        wr(4'd7, 8'h00); wr(4'd7, 8'h00);
        wr(4'd12, 8'h07);
        rd(4'd8, 4'h8, d);
        chk("R10 read returns old flags", d, 8'h02);
        rd_chk("R10 new flag survives read", 4'd8, 8'h08);

        idle();
        idle();
        summary();
    end

endmodule